// File: doc/BRIEF.md
# Asynchronous SRAM Write Cycle Sequencer

This block turns a single write request into a complete, correctly timed write cycle on an external asynchronous static RAM. On the user side, a ready/valid port accepts one request at a time. A request carries an address, a data byte, a target select (memory array or semaphore space), a write style and an output-enable choice. On the RAM side the block drives the address bus, the data bus (as a value plus a pad driver enable), an active-low chip enable, an active-low semaphore select, an active-low write strobe and an active-low output enable. Every pin is registered.

Every interval is a parameter counted in clock cycles. These are address setup, minimum write pulse, RAM output turn-off, data setup, data hold and write recovery. The block supports two write styles. In the strobe-controlled style, the enable falls first and the write strobe falls last and rises first. In the enable-controlled style, the roles swap. When the output enable is kept low during a strobe-controlled write, the RAM is still driving its outputs when the strobe falls. In that case the block delays its own data driver and lengthens the write window to cover it. The block signals completion with a one-cycle pulse once the recovery count has run out.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, the write strobe, chip enable, semaphore select and output enable are all high, the data driver enable is low, req_ready is high and done is low.
- R2: A request with req_sem=0 lowers only ram_ce_n (ram_sem_n stays high). A request with req_sem=1 lowers only ram_sem_n (ram_ce_n stays high). The two are never low together.
- R3: ram_addr equals the accepted request address whenever any strobe is low. It changes only on a cycle in which the write strobe is high or both enables are high.
- R4: Counting cycle 0 as the first cycle after acceptance, the first strobe falls in cycle 0 and the last strobe falls in cycle T_AS. With req_en_ctl=0 the enable falls first. With req_en_ctl=1 the write strobe falls first.
- R5: The window where the write strobe and the selected enable are both low starts in cycle T_AS. With req_en_ctl=0 and req_keep_oe=1, it lasts max(T_WP, T_WZ+T_DW) cycles. Otherwise it lasts max(T_WP, T_DW) cycles.
- R6: With req_en_ctl=0 and req_keep_oe=1, the data driver turns on in cycle T_AS+T_WZ. In all other cases it turns on in cycle 0.
- R7: The data driver stays on for T_DH cycles after the write window ends, then turns off. While it is on, ram_dq_o equals the request data.
- R8: The controlling strobe rises first: the write strobe when req_en_ctl=0, the enable when req_en_ctl=1. The other strobe rises max(T_WR, T_DH) cycles later. done is high for exactly one cycle, the cycle after that, and all strobes are high then.
- R9: req_ready is low from acceptance until the done cycle. A request held valid while busy is not accepted and changes nothing.
- R10: ram_oe_n is low during a cycle exactly when req_keep_oe=1, and high in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on valid |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_sem | input | 1 | 1 = semaphore space, 0 = memory array |
| req_en_ctl | input | 1 | 1 = enable-controlled, 0 = strobe-controlled write |
| req_keep_oe | input | 1 | Hold output enable low during the cycle |
| done | output | 1 | One-cycle completion pulse |
| ram_addr | output | ADDR_W | RAM address bus |
| ram_dq_o | output | DATA_W | RAM data bus value |
| ram_dq_oe | output | 1 | RAM data bus driver enable |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_sem_n | output | 1 | Semaphore select, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions check the following on every cycle:
- the address never moves while both strobes are low;
- the array and semaphore selects are never low together;
- done is a single-cycle pulse and finds every strobe high with the driver off;
- when the output enable is kept low, the data driver never switches on in the same cycle that the selected RAM sees its write strobe fall.

Only the directed scenarios can show the measured cycle counts, because they depend on the request's mode and output-enable choice. These counts are the strobe fall order, the write window length, the driver turn-on and turn-off positions, the recovery length and the data presented at the end of the window.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_REC   = 2'd3
    } wseq_st_e;

    typedef struct packed {
        logic we_n;
        logic ce_n;
        logic sem_n;
        logic oe_n;
        logic dq_oe;
    } wseq_pins_t;

    localparam wseq_pins_t PINS_IDLE = '{we_n: 1'b1, ce_n: 1'b1, sem_n: 1'b1,
                                         oe_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d
);

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sram_wr_pinmux.sv
module sram_wr_pinmux
    import sram_wr_pkg::*;
#(
    parameter int CW   = 4,
    parameter int T_WZ = 2,
    parameter int T_DH = 1
) (
    input  wseq_st_e      st,
    input  logic [CW-1:0] cnt,
    input  logic          rw_ctl,
    input  logic          tgt_sem,
    input  logic          keep_oe,
    output wseq_pins_t    pins
);

    logic busy;
    logic en_low;
    logic we_low;
    logic late_drive;

    always_comb begin
        busy       = (st != ST_IDLE);
        late_drive = rw_ctl && keep_oe;
        // strobe-controlled: enable frames the cycle, write strobe marks the window
        // enable-controlled: write strobe frames the cycle, enable marks the window
        en_low     = rw_ctl ? busy : (st == ST_PULSE);
        we_low     = rw_ctl ? (st == ST_PULSE) : busy;

        pins.we_n  = !we_low;
        pins.ce_n  = !(en_low && !tgt_sem);
        pins.sem_n = !(en_low && tgt_sem);
        pins.oe_n  = !(busy && keep_oe);

        unique case (st)
            ST_SETUP: pins.dq_oe = !late_drive;
            ST_PULSE: pins.dq_oe = late_drive ? (cnt >= CW'(T_WZ)) : 1'b1;
            ST_REC:   pins.dq_oe = (cnt < CW'(T_DH));
            default:  pins.dq_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int T_AS   = 2,
    parameter int T_WP   = 3,
    parameter int T_WZ   = 2,
    parameter int T_DW   = 2,
    parameter int T_DH   = 1,
    parameter int T_WR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_sem,
    input  logic              req_en_ctl,
    input  logic              req_keep_oe,
    output logic              done,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    output logic              ram_ce_n,
    output logic              ram_sem_n,
    output logic              ram_we_n,
    output logic              ram_oe_n
);

    localparam int P_LATE  = (T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW;
    localparam int P_EARLY = (T_WP > T_DW) ? T_WP : T_DW;
    localparam int R_LEN   = (T_WR > T_DH) ? T_WR : T_DH;
    localparam int M_A     = (P_LATE > R_LEN) ? P_LATE : R_LEN;
    localparam int M_ALL   = (M_A > T_AS) ? M_A : T_AS;
    localparam int CW      = $clog2(M_ALL + 1);

    typedef struct packed {
        wseq_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              sem;
        logic              rw;
        logic              keep;
        logic              done;
        wseq_pins_t        pins;
    } regs_t;

    regs_t         r_q, r_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_clr;
    logic [CW-1:0] plen_last;
    wseq_pins_t    pins_nx;

    sram_wr_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d)
    );

    sram_wr_pinmux #(.CW(CW), .T_WZ(T_WZ), .T_DH(T_DH)) u_pinmux (
        .st      (r_d.st),
        .cnt     (cnt_d),
        .rw_ctl  (r_d.rw),
        .tgt_sem (r_d.sem),
        .keep_oe (r_d.keep),
        .pins    (pins_nx)
    );

    always_comb begin
        plen_last = (r_q.rw && r_q.keep) ? CW'(P_LATE - 1) : CW'(P_EARLY - 1);
        r_d       = r_q;
        r_d.done  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_SETUP;
                    r_d.addr = req_addr;
                    r_d.data = req_data;
                    r_d.sem  = req_sem;
                    r_d.rw   = !req_en_ctl;
                    r_d.keep = req_keep_oe;
                end
            end
            ST_SETUP: if (cnt_q == CW'(T_AS - 1)) r_d.st = ST_PULSE;
            ST_PULSE: if (cnt_q == plen_last)     r_d.st = ST_REC;
            ST_REC: begin
                if (cnt_q == CW'(R_LEN - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        cnt_clr  = (r_d.st != r_q.st);
        r_d.pins = pins_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.pins <= PINS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign done      = r_q.done;
    assign ram_addr  = r_q.addr;
    assign ram_dq_o  = r_q.data;
    assign ram_dq_oe = r_q.pins.dq_oe;
    assign ram_ce_n  = r_q.pins.ce_n;
    assign ram_sem_n = r_q.pins.sem_n;
    assign ram_we_n  = r_q.pins.we_n;
    assign ram_oe_n  = r_q.pins.oe_n;

    // R3
    addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_addr) |-> (ram_we_n || (ram_ce_n && ram_sem_n)));

    // R2
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_ce_n && !ram_sem_n));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_we_n && ram_ce_n && ram_sem_n && !ram_dq_oe));

    // R6
    late_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ram_dq_oe) && !ram_oe_n && !(ram_ce_n && ram_sem_n))
        |-> ($past(!ram_we_n) && $past(!(ram_ce_n && ram_sem_n))));

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/tb_sram_wr_seq.sv
module tb_sram_wr_seq;

    localparam int AW = 13, DW = 8;
    localparam int T_AS = 2, T_WP = 3, T_WZ = 2, T_DW = 2, T_DH = 1, T_WR = 2;
    localparam int P_LATE  = (T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW;
    localparam int P_EARLY = (T_WP > T_DW) ? T_WP : T_DW;
    localparam int R_LEN   = (T_WR > T_DH) ? T_WR : T_DH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_sem = 1'b0, req_en_ctl = 1'b0, req_keep_oe = 1'b0;
    logic done;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_dq_o;
    logic ram_dq_oe, ram_ce_n, ram_sem_n, ram_we_n, ram_oe_n;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
                  .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_sem(req_sem),
        .req_en_ctl(req_en_ctl), .req_keep_oe(req_keep_oe), .done(done),
        .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
        .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk(ram_we_n && ram_ce_n && ram_sem_n && ram_oe_n, "R1 strobes",
            {ram_we_n, ram_ce_n, ram_sem_n, ram_oe_n}, 15);
        chk(!ram_dq_oe && req_ready && !done, "R1 driver/ready/done",
            {ram_dq_oe, req_ready, done}, 2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Runs one write and measures every pin; hold_busy keeps a stray request valid while busy.
    task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit sem, input bit enc, input bit keep, input bit hold_busy);
        int en_first = -1, en_last = -1, we_first = -1, we_last = -1;
        int ov_first = -1, ov_last = -1, dv_first = -1, dv_last = -1;
        int done_idx = -1, done_cnt = 0;
        int sel_bad = 0, addr_bad = 0, data_bad = 0, rdy_bad = 0, oe_bad = 0, late_bad = 0;
        int plen, dexp;
        bit en_low, we_low, busy;
        req_addr = a; req_data = d; req_sem = sem; req_en_ctl = enc; req_keep_oe = keep;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (hold_busy) begin
            req_addr = ~a; req_data = ~d;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k < 20; k++) begin
            if (k == 4) req_valid = 1'b0;
            en_low = sem ? !ram_sem_n : !ram_ce_n;
            we_low = !ram_we_n;
            busy   = (done_idx < 0);
            if (sem ? !ram_ce_n : !ram_sem_n) sel_bad++;
            if (en_low && en_first < 0) en_first = k;
            if (en_low) en_last = k;
            if (we_low && we_first < 0) we_first = k;
            if (we_low) we_last = k;
            if (en_low && we_low && ov_first < 0) ov_first = k;
            if (en_low && we_low) ov_last = k;
            if (ram_dq_oe && dv_first < 0) dv_first = k;
            if (ram_dq_oe) dv_last = k;
            if (ram_dq_oe && ram_dq_o != d) data_bad++;
            if ((en_low || we_low) && ram_addr != a) addr_bad++;
            if (done) begin
                done_cnt++;
                if (done_idx < 0) done_idx = k;
                busy = 1'b0;
            end
            if (busy && req_ready) rdy_bad++;
            if (busy && ram_oe_n != !keep) oe_bad++;
            if (!busy && !ram_oe_n) oe_bad++;
            if (done_idx >= 0 && k > done_idx && (en_low || we_low || ram_dq_oe)) late_bad++;
            @(negedge clk);
        end
        plen = (!enc && keep) ? P_LATE : P_EARLY;
        dexp = (!enc && keep) ? T_AS + T_WZ : 0;
        // R2
        chk(sel_bad == 0 && en_first >= 0, "R2 target select", sel_bad, 0);
        // R3
        chk(addr_bad == 0, "R3 address held", addr_bad, 0);
        // R4
        chk(enc ? (we_first == 0 && en_first == T_AS) : (en_first == 0 && we_first == T_AS),
            "R4 last strobe fall", enc ? en_first : we_first, T_AS);
        // R5
        chk(ov_first == T_AS, "R5 window start", ov_first, T_AS);
        chk(ov_last - ov_first + 1 == plen, "R5 window length", ov_last - ov_first + 1, plen);
        // R6
        chk(dv_first == dexp, "R6 driver on", dv_first, dexp);
        // R7
        chk(dv_last == T_AS + plen + T_DH - 1, "R7 driver off", dv_last, T_AS + plen + T_DH - 1);
        chk(data_bad == 0, "R7 data value", data_bad, 0);
        // R8
        chk((enc ? en_last : we_last) == T_AS + plen - 1, "R8 controlling rise",
            enc ? en_last : we_last, T_AS + plen - 1);
        chk((enc ? we_last : en_last) == T_AS + plen + R_LEN - 1, "R8 recovery",
            enc ? we_last : en_last, T_AS + plen + R_LEN - 1);
        chk(done_idx == T_AS + plen + R_LEN && done_cnt == 1, "R8 done pulse",
            done_idx, T_AS + plen + R_LEN);
        // R9
        chk(rdy_bad == 0 && late_bad == 0, "R9 busy/no second cycle", rdy_bad + late_bad, 0);
        // R10
        chk(oe_bad == 0, "R10 output enable", oe_bad, 0);
    endtask

    task automatic t_array_rw_oe();   run_write(13'h0A5, 8'h3C, 0, 0, 1, 0); endtask
    task automatic t_array_rw_nooe(); run_write(13'h1FFF, 8'hC3, 0, 0, 0, 0); endtask
    task automatic t_sem_en();        run_write(13'h0007, 8'h01, 1, 1, 0, 0); endtask
    task automatic t_array_en_oe();   run_write(13'h1234, 8'h5A, 0, 1, 1, 0); endtask
    task automatic t_sem_rw_oe();     run_write(13'h0000, 8'hFF, 1, 0, 1, 0); endtask
    task automatic t_busy_ignore();   run_write(13'h0800, 8'h81, 0, 0, 0, 1); endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_array_rw_oe();
        t_array_rw_nooe();
        t_sem_en();
        t_array_en_oe();
        t_sem_rw_oe();
        t_busy_ignore();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule